// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front End

This block is the software-facing side of a byte-oriented I2C master. It sits on a simple 32-bit register bus with a write strobe, a word address and combinational read data. It holds four registers: control, status, data buffer and bus monitor. A separate byte engine does the actual bus signalling. The front end hands that engine one command at a time through a valid/ready handshake. It turns the engine's one-cycle event pulses into sticky status bits, which software clears by writing 1 to them. It also produces a single level interrupt from those status bits and their per-source enables.

Software configures the unit through the control register: enable, bus speed, clock drive and interrupt enables. It loads a byte into the data buffer. It then writes the control register with the transfer trigger set, together with the start, stop and acknowledge choice for that byte. The trigger bit reads back as 1 until the engine has accepted the command. A unit-reset bit holds the engine and the front end in their idle state until software writes it back to 0.

Top module: `i2cr_regs`

## Requirements
- R1: After reset every register reads 0, and irq, cmd_valid and unit_rst are low.
- R2: The control register is at offset 0x00. Only bits 0-3, 8, 10, 13, 14, 18-22, 25 and 26 are storable (write mask 0x067C650F). Bit 3 obeys R3/R5. All other bits read 0.
- R3: Writing control with bit 3 = 1, bit 14 = 1 and bit 10 = 0 raises cmd_valid in the next cycle. cmd_start, cmd_stop and cmd_nak follow control bits 0, 1 and 2, and cmd_byte carries the data buffer. cmd_valid and bit 3 stay at 1 until a cycle with cmd_ready high, and bit 3 reads 0 from the following cycle.
- R4: While bit 3 reads 1, a control write leaves bits 3..0 unchanged and updates all other storable bits.
- R5: A control write with bit 3 = 1 launches nothing, and bit 3 reads 0, if the same word has bit 14 = 0 or bit 10 = 1. A pending command is dropped once bit 14 reads 0 or bit 10 reads 1.
- R6: Status (offset 0x04) bits 18, 19, 20 and 22 are sticky. They are set by the arbitration-loss, transmit-empty, receive-full and bus-error event pulses respectively. Bit 26 is set by the master-stop pulse, but only while control bit 26 is 1. Writing status clears exactly the sticky bits written as 1. An event in the same cycle as a clear wins.
- R7: Status bits 14, 15, 16 and 17 show the live levels of received-NAK, unit busy, bus busy and early bus busy. Status writes never change them. All other status bits read 0.
- R8: The data buffer (offset 0x0C) stores the low byte of a write and reads it zero-extended. A receive-full event loads rx_byte, and this has priority over a write in the same cycle.
- R9: The bus monitor (offset 0x1C) reads live SDA in bit 0 and live SCL in bit 1, with all other bits 0.
- R10: irq is high exactly when control bit 14 is 1, control bit 10 is 0, and at least one enabled pair holds. The pairs are status/enable 18/18, 19/19, 20/20, 22/22 and status 26 with enable 25.
- R11: While control bit 10 reads 1, unit_rst is high, the sticky status bits and the data buffer are held at 0, and incoming events are ignored.
- R12: Any other offset reads 0, and writes to it change no register.
- R13: fast_mode, scl_drive_en, unit_en and gcall_off follow control bits 8, 13, 14 and 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cmd_valid | output | 1 | Byte command pending for the engine |
| cmd_ready | input | 1 | Engine accepts the pending command |
| cmd_start | output | 1 | Issue a start condition before the byte |
| cmd_stop | output | 1 | Issue a stop condition after the byte |
| cmd_nak | output | 1 | Answer a received byte with NAK (1) or ACK (0) |
| cmd_byte | output | 8 | Byte to transmit (data buffer) |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_tx_empty | input | 1 | Pulse: transmit buffer emptied |
| ev_rx_full | input | 1 | Pulse: byte received into rx_byte |
| rx_byte | input | 8 | Received byte |
| ev_bus_err | input | 1 | Pulse: no acknowledge seen |
| ev_master_stop | input | 1 | Pulse: stop condition sent by this master |
| lvl_nak | input | 1 | Level: last acknowledge bit was NAK |
| lvl_unit_busy | input | 1 | Level: engine busy |
| lvl_bus_busy | input | 1 | Level: bus busy |
| lvl_early_busy | input | 1 | Level: bus busy, early indication |
| sda_in | input | 1 | Live SDA level |
| scl_in | input | 1 | Live SCL level |
| unit_rst | output | 1 | Hold engine in reset |
| unit_en | output | 1 | Unit enable |
| fast_mode | output | 1 | Fast bus speed select |
| scl_drive_en | output | 1 | Allow the engine to drive SCL |
| gcall_off | output | 1 | Ignore general-call address |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with the default ADDR_W of 5. This width spans every register offset up to 0x1C plus unassigned words at 0x08, 0x10, 0x14 and 0x18, so address decode and the read-zero rule are both reachable. Directed sequences cover the following: a command held pending across several stalled cycles while control is rewritten, an event colliding with its own clear, a received byte colliding with a software write, and a reset asserted over a pending command. A random phase then mixes writes, events and ready stalls against the reference model.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;

    // register byte offsets (fixed: software decodes them)
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_STAT = 'h04;
    localparam int OFS_DATA = 'h0C;
    localparam int OFS_MON  = 'h1C;

    // control bit positions
    localparam int C_START    = 0;
    localparam int C_STOP     = 1;
    localparam int C_NAK      = 2;
    localparam int C_XFER     = 3;
    localparam int CMD_W      = C_XFER + 1;
    localparam int C_FAST     = 8;
    localparam int C_URST     = 10;
    localparam int C_SCLEN    = 13;
    localparam int C_UEN      = 14;
    localparam int C_IE_ARB   = 18;
    localparam int C_IE_TXE   = 19;
    localparam int C_IE_RXF   = 20;
    localparam int C_GCOFF    = 21;
    localparam int C_IE_BERR  = 22;
    localparam int C_IE_MSTOP = 25;
    localparam int C_MSTOP_EN = 26;

    // status bit positions
    localparam int S_ACK   = 14;
    localparam int S_UBUSY = 15;
    localparam int S_BBUSY = 16;
    localparam int S_EBUSY = 17;
    localparam int S_ARB   = 18;
    localparam int S_TXE   = 19;
    localparam int S_RXF   = 20;
    localparam int S_BERR  = 22;
    localparam int S_MSTOP = 26;

    // event sources, index into the tables below
    localparam int SRC_N     = 5;
    localparam int SRC_ARB   = 0;
    localparam int SRC_TXE   = 1;
    localparam int SRC_RXF   = 2;
    localparam int SRC_BERR  = 3;
    localparam int SRC_MSTOP = 4;

    localparam int SRC_STAT_BIT [SRC_N] = '{S_ARB, S_TXE, S_RXF, S_BERR, S_MSTOP};
    localparam int SRC_EN_BIT   [SRC_N] = '{C_IE_ARB, C_IE_TXE, C_IE_RXF, C_IE_BERR, C_IE_MSTOP};

    localparam logic [REG_W-1:0] CTRL_WMASK =
        (REG_W'(1) << C_START)   | (REG_W'(1) << C_STOP)     | (REG_W'(1) << C_NAK)    |
        (REG_W'(1) << C_XFER)    | (REG_W'(1) << C_FAST)     | (REG_W'(1) << C_URST)   |
        (REG_W'(1) << C_SCLEN)   | (REG_W'(1) << C_UEN)      | (REG_W'(1) << C_IE_ARB) |
        (REG_W'(1) << C_IE_TXE)  | (REG_W'(1) << C_IE_RXF)   | (REG_W'(1) << C_GCOFF)  |
        (REG_W'(1) << C_IE_BERR) | (REG_W'(1) << C_IE_MSTOP) | (REG_W'(1) << C_MSTOP_EN);

    localparam logic [REG_W-1:0] STICKY_MASK =
        (REG_W'(1) << S_ARB) | (REG_W'(1) << S_TXE) | (REG_W'(1) << S_RXF) |
        (REG_W'(1) << S_BERR) | (REG_W'(1) << S_MSTOP);

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CTRL,
        RS_STAT,
        RS_DATA,
        RS_MON
    } reg_sel_e;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
    } ctrl_st_t;

    typedef struct packed {
        logic [REG_W-1:0] sticky;
    } stat_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] dbr;
    } data_st_t;

endpackage

// File: rtl/i2cr_ctrl.sv
module i2cr_ctrl
    import i2cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             cmd_ready,
    output logic [REG_W-1:0] ctrl_q,
    output logic             cmd_valid
);

    ctrl_st_t st_d, st_q;
    logic              drop;
    logic              accept;
    logic [REG_W-1:0]  wmasked;

    always_comb begin
        st_d    = st_q;
        drop    = st_q.ctrl[C_URST] | ~st_q.ctrl[C_UEN];
        accept  = st_q.ctrl[C_XFER] & ~drop & cmd_ready;
        wmasked = wdata & CTRL_WMASK;
        if (accept || drop) begin
            st_d.ctrl[C_XFER] = 1'b0;
        end
        if (wr_en) begin
            if (st_q.ctrl[C_XFER]) begin
                // command fields frozen while a byte is pending
                st_d.ctrl = {wmasked[REG_W-1:CMD_W], st_d.ctrl[CMD_W-1:0]};
            end else begin
                st_d.ctrl = wmasked;
                if (!wmasked[C_UEN] || wmasked[C_URST]) begin
                    st_d.ctrl[C_XFER] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q    = st_q.ctrl;
    assign cmd_valid = st_q.ctrl[C_XFER] & ~st_q.ctrl[C_URST] & st_q.ctrl[C_UEN];

    // R3: an unanswered command stays valid with stable fields
    a_r3_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready && !wr_en |=> cmd_valid && $stable(ctrl_q[C_NAK:C_START]));

    // R3: acceptance retires the trigger bit
    a_r3_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !ctrl_q[C_XFER]);

    // R4: writes during a pending command keep the command fields
    a_r4_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && ctrl_q[C_XFER] |=> ctrl_q[C_NAK:C_START] == $past(ctrl_q[C_NAK:C_START]));

    // R5: no launch from a word with the unit disabled
    a_r5_no_launch_off: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !ctrl_q[C_XFER] && !wdata[C_UEN] |=> !cmd_valid);

endmodule

// File: rtl/i2cr_stat.sv
module i2cr_stat
    import i2cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clr,
    input  logic             clr_wr,
    input  logic [REG_W-1:0] clr_mask,
    input  logic [SRC_N-1:0] ev,
    input  logic             mstop_en,
    output logic [REG_W-1:0] sticky_q
);

    stat_st_t         st_d, st_q;
    logic [REG_W-1:0] set_vec;
    logic [SRC_N-1:0] ev_ok;

    always_comb begin
        ev_ok            = ev;
        ev_ok[SRC_MSTOP] = ev[SRC_MSTOP] & mstop_en;
        set_vec          = '0;
        for (int i = 0; i < SRC_N; i++) begin
            set_vec[SRC_STAT_BIT[i]] = ev_ok[i];
        end
        st_d = st_q;
        if (clr_wr) begin
            st_d.sticky = st_d.sticky & ~(clr_mask & STICKY_MASK);
        end
        st_d.sticky = st_d.sticky | set_vec;
        if (hold_clr) begin
            st_d.sticky = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sticky_q = st_q.sticky;

    // R6: an arbitration-loss pulse is always recorded outside reset
    a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev[SRC_ARB] && !hold_clr |=> sticky_q[S_ARB]);

    // R6: a quiet clear removes exactly the marked bits
    a_r6_w1c_exact: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !hold_clr && ev == '0 |=> sticky_q == ($past(sticky_q) & ~$past(clr_mask)));

    // R11: reset empties the sticky bits
    a_r11_stat_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> sticky_q == '0);

endmodule

// File: rtl/i2cr_data.sv
module i2cr_data
    import i2cr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_clr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              rx_ev,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [BYTE_W-1:0] dbr_q
);

    data_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_clr) begin
            st_d.dbr = '0;
        end else if (rx_ev) begin
            st_d.dbr = rx_byte;
        end else if (wr_en) begin
            st_d.dbr = wbyte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbr_q = st_q.dbr;

    // R8: a received byte wins over a same-cycle write
    a_r8_rx_wins: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ev && !hold_clr |=> dbr_q == $past(rx_byte));

    // R11: reset empties the buffer
    a_r11_data_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hold_clr |=> dbr_q == '0);

endmodule

// File: rtl/i2cr_irq.sv
module i2cr_irq
    import i2cr_pkg::*;
(
    input  logic [REG_W-1:0] sticky,
    input  logic [REG_W-1:0] ctrl,
    output logic             irq
);

    logic [SRC_N-1:0] hit;

    for (genvar g = 0; g < SRC_N; g++) begin : g_src
        assign hit[g] = sticky[SRC_STAT_BIT[g]] & ctrl[SRC_EN_BIT[g]];
    end

    assign irq = ctrl[C_UEN] & ~ctrl[C_URST] & (|hit);

endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs
    import i2cr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_nak,
    output logic [7:0]        cmd_byte,
    input  logic              ev_arb_lost,
    input  logic              ev_tx_empty,
    input  logic              ev_rx_full,
    input  logic [7:0]        rx_byte,
    input  logic              ev_bus_err,
    input  logic              ev_master_stop,
    input  logic              lvl_nak,
    input  logic              lvl_unit_busy,
    input  logic              lvl_bus_busy,
    input  logic              lvl_early_busy,
    input  logic              sda_in,
    input  logic              scl_in,
    output logic              unit_rst,
    output logic              unit_en,
    output logic              fast_mode,
    output logic              scl_drive_en,
    output logic              gcall_off,
    output logic              irq
);

    reg_sel_e          sel;
    logic [REG_W-1:0]  ctrl_q;
    logic [REG_W-1:0]  sticky_q;
    logic [BYTE_W-1:0] dbr_q;
    logic [REG_W-1:0]  lvl_word;
    logic [SRC_N-1:0]  ev_vec;
    logic              in_reset;

    always_comb begin
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            sel = RS_CTRL;
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            sel = RS_STAT;
        end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
            sel = RS_DATA;
        end else if (bus_addr == ADDR_W'(OFS_MON)) begin
            sel = RS_MON;
        end else begin
            sel = RS_NONE;
        end
    end

    always_comb begin
        ev_vec            = '0;
        ev_vec[SRC_ARB]   = ev_arb_lost;
        ev_vec[SRC_TXE]   = ev_tx_empty;
        ev_vec[SRC_RXF]   = ev_rx_full;
        ev_vec[SRC_BERR]  = ev_bus_err;
        ev_vec[SRC_MSTOP] = ev_master_stop;
    end

    i2cr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && sel == RS_CTRL),
        .wdata     (bus_wdata),
        .cmd_ready (cmd_ready),
        .ctrl_q    (ctrl_q),
        .cmd_valid (cmd_valid)
    );

    assign in_reset = ctrl_q[C_URST];

    i2cr_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (in_reset),
        .clr_wr   (bus_wr && sel == RS_STAT),
        .clr_mask (bus_wdata),
        .ev       (ev_vec),
        .mstop_en (ctrl_q[C_MSTOP_EN]),
        .sticky_q (sticky_q)
    );

    i2cr_data u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (in_reset),
        .wr_en    (bus_wr && sel == RS_DATA),
        .wbyte    (bus_wdata[BYTE_W-1:0]),
        .rx_ev    (ev_rx_full),
        .rx_byte  (rx_byte),
        .dbr_q    (dbr_q)
    );

    i2cr_irq u_irq (
        .sticky (sticky_q),
        .ctrl   (ctrl_q),
        .irq    (irq)
    );

    always_comb begin
        lvl_word          = '0;
        lvl_word[S_ACK]   = lvl_nak;
        lvl_word[S_UBUSY] = lvl_unit_busy;
        lvl_word[S_BBUSY] = lvl_bus_busy;
        lvl_word[S_EBUSY] = lvl_early_busy;
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RS_CTRL: bus_rdata = ctrl_q;
            RS_STAT: bus_rdata = sticky_q | lvl_word;
            RS_DATA: bus_rdata = {{(REG_W-BYTE_W){1'b0}}, dbr_q};
            RS_MON:  bus_rdata = {{(REG_W-2){1'b0}}, scl_in, sda_in};
            default: bus_rdata = '0;
        endcase
    end

    assign cmd_start    = ctrl_q[C_START];
    assign cmd_stop     = ctrl_q[C_STOP];
    assign cmd_nak      = ctrl_q[C_NAK];
    assign cmd_byte     = dbr_q;
    assign unit_rst     = in_reset;
    assign unit_en      = ctrl_q[C_UEN];
    assign fast_mode    = ctrl_q[C_FAST];
    assign scl_drive_en = ctrl_q[C_SCLEN];
    assign gcall_off    = ctrl_q[C_GCOFF];

    // R10: a disabled unit never interrupts
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |-> !irq);

    // R11: no command is offered while the unit is held in reset
    a_r11_no_cmd_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        unit_rst |-> !cmd_valid);

    // R12: unassigned offsets read zero
    a_r12_hole_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sel == RS_NONE |-> bus_rdata == '0);

endmodule

// File: tb/tb_i2cr_regs.sv
`timescale 1ns/1ps
module tb_i2cr_regs;

    localparam int AW = 5;
    localparam logic [31:0] WMASK = 32'h067C650F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic cmd_valid, cmd_start, cmd_stop, cmd_nak;
    logic [7:0] cmd_byte;
    logic cmd_ready = 0;
    logic ev_arb_lost = 0, ev_tx_empty = 0, ev_rx_full = 0, ev_bus_err = 0, ev_master_stop = 0;
    logic [7:0] rx_byte = '0;
    logic lvl_nak = 0, lvl_unit_busy = 0, lvl_bus_busy = 0, lvl_early_busy = 0;
    logic sda_in = 1, scl_in = 1;
    logic unit_rst, unit_en, fast_mode, scl_drive_en, gcall_off, irq;

    i2cr_regs #(.ADDR_W(AW)) dut (.*);

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cmp_on = 0;

    // behavioural reference state
    logic [31:0] m_ctrl, m_st;
    logic [7:0]  m_dbr;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_valid();
        return m_ctrl[3] && m_ctrl[14] && !m_ctrl[10];
    endfunction

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        case (a)
            5'h00: return m_ctrl;
            5'h04: return m_st | {14'd0, lvl_early_busy, lvl_bus_busy, lvl_unit_busy, lvl_nak, 14'd0};
            5'h0C: return {24'd0, m_dbr};
            5'h1C: return {30'd0, scl_in, sda_in};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic m_irq();
        logic any;
        any = (m_st[18] && m_ctrl[18]) || (m_st[19] && m_ctrl[19]) || (m_st[20] && m_ctrl[20])
           || (m_st[22] && m_ctrl[22]) || (m_st[26] && m_ctrl[25]);
        return any && m_ctrl[14] && !m_ctrl[10];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [31:0] nc, ns, w, setv;
        logic [7:0]  nd;
        if (!rst_n) begin
            m_ctrl = '0; m_st = '0; m_dbr = '0;
        end else begin
            nc = m_ctrl;
            if ((m_valid() && cmd_ready) || m_ctrl[10] || !m_ctrl[14]) nc[3] = 1'b0;
            if (bus_wr && bus_addr == 5'h00) begin
                w = bus_wdata & WMASK;
                if (m_ctrl[3]) nc = {w[31:4], nc[3:0]};
                else begin
                    nc = w;
                    if (!w[14] || w[10]) nc[3] = 1'b0;
                end
            end
            setv = '0;
            setv[18] = ev_arb_lost; setv[19] = ev_tx_empty; setv[20] = ev_rx_full;
            setv[22] = ev_bus_err;  setv[26] = ev_master_stop && m_ctrl[26];
            ns = m_st;
            if (bus_wr && bus_addr == 5'h04) ns = ns & ~bus_wdata;
            ns = ns | setv;
            nd = m_dbr;
            if (ev_rx_full) nd = rx_byte;
            else if (bus_wr && bus_addr == 5'h0C) nd = bus_wdata[7:0];
            if (m_ctrl[10]) begin ns = '0; nd = '0; end
            m_ctrl = nc; m_st = ns; m_dbr = nd;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R10 irq", {31'd0, irq}, {31'd0, m_irq()});
            chk("R3 cmd_valid", {31'd0, cmd_valid}, {31'd0, m_valid()});
            chk("R3 cmd fields", {28'd0, cmd_start, cmd_stop, cmd_nak, 1'b0},
                {28'd0, m_ctrl[0], m_ctrl[1], m_ctrl[2], 1'b0});
            chk("R3 cmd_byte", {24'd0, cmd_byte}, {24'd0, m_dbr});
            chk("R11 unit_rst", {31'd0, unit_rst}, {31'd0, m_ctrl[10]});
            chk("R13 outputs", {28'd0, fast_mode, scl_drive_en, unit_en, gcall_off},
                {28'd0, m_ctrl[8], m_ctrl[13], m_ctrl[14], m_ctrl[21]});
            case (bus_addr)
                5'h00: chk("R2 ctrl read", bus_rdata, m_read(bus_addr));
                5'h04: chk("R6 status read", bus_rdata, m_read(bus_addr));
                5'h0C: chk("R8 data read", bus_rdata, m_read(bus_addr));
                5'h1C: chk("R9 monitor read", bus_rdata, m_read(bus_addr));
                default: chk("R12 hole read", bus_rdata, m_read(bus_addr));
            endcase
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
        tick();
    endtask

    task automatic sig(input string tag, input logic act, input logic exp);
        @(negedge clk);
        chk(tag, {31'd0, act}, {31'd0, exp});
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        cmp_on = 1;
        // R1 reset state
        rd(5'h00, 32'h0, "R1 ctrl");
        rd(5'h04, 32'h0, "R1 status");
        rd(5'h0C, 32'h0, "R1 data");
        sig("R1 irq", irq, 1'b0);
        sig("R1 cmd_valid", cmd_valid, 1'b0);
        sig("R1 unit_rst", unit_rst, 1'b0);

        // R2 mask, R13 outputs
        wr(5'h00, 32'hFFFF_FBF7);
        rd(5'h00, 32'h067C_6107, "R2 ctrl mask");
        sig("R13 fast_mode", fast_mode, 1'b1);
        sig("R13 gcall_off", gcall_off, 1'b1);
        wr(5'h00, 32'h0000_4000);

        // R8 data buffer
        wr(5'h0C, 32'h0000_A5A5);
        rd(5'h0C, 32'h0000_00A5, "R8 data write");

        // R3 launch, R4 frozen fields
        wr(5'h00, 32'h0000_4009);
        sig("R3 valid raised", cmd_valid, 1'b1);
        wr(5'h00, 32'h0000_4102);
        rd(5'h00, 32'h0000_4109, "R4 frozen fields");
        sig("R3 still valid", cmd_valid, 1'b1);
        cmd_ready = 1; tick(); cmd_ready = 0;
        rd(5'h00, 32'h0000_4101, "R3 trigger retired");

        // R5 no launch
        wr(5'h00, 32'h0000_0008);
        rd(5'h00, 32'h0, "R5 disabled launch");
        wr(5'h00, 32'h0000_4408);
        rd(5'h00, 32'h0000_4400, "R5 reset launch");
        wr(5'h00, 32'h0);

        // R6 sticky and W1C, R10 irq
        wr(5'h00, 32'h065C_4000);
        ev_arb_lost = 1; tick(); ev_arb_lost = 0;
        rd(5'h04, 32'h0004_0000, "R6 arb sticky");
        sig("R10 irq arb", irq, 1'b1);
        wr(5'h04, 32'h0004_0000);
        rd(5'h04, 32'h0, "R6 w1c");
        ev_master_stop = 1; tick(); ev_master_stop = 0;
        rd(5'h04, 32'h0400_0000, "R6 mstop sticky");
        sig("R10 irq mstop", irq, 1'b1);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h00, 32'h025C_4000);
        ev_master_stop = 1; tick(); ev_master_stop = 0;
        rd(5'h04, 32'h0, "R6 mstop detect off");
        ev_tx_empty = 1; wr(5'h04, 32'h0008_0000); ev_tx_empty = 0;
        rd(5'h04, 32'h0008_0000, "R6 event beats clear");
        wr(5'h00, 32'h0000_4000);
        sig("R10 source not enabled", irq, 1'b0);
        wr(5'h00, 32'h0008_0000);
        sig("R10 unit disabled", irq, 1'b0);
        wr(5'h00, 32'h0008_4000);
        sig("R10 enabled source", irq, 1'b1);
        wr(5'h04, 32'h0008_0000);

        // R7 levels
        lvl_nak = 1; lvl_unit_busy = 1; lvl_bus_busy = 1; lvl_early_busy = 1;
        rd(5'h04, 32'h0003_C000, "R7 levels");
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, 32'h0003_C000, "R7 levels survive w1c");
        lvl_nak = 0; lvl_unit_busy = 0; lvl_bus_busy = 0; lvl_early_busy = 0;

        // R9 bus monitor
        sda_in = 1; scl_in = 0;
        rd(5'h1C, 32'h1, "R9 sda only");
        sda_in = 0; scl_in = 1;
        rd(5'h1C, 32'h2, "R9 scl only");
        sda_in = 1;

        // R12 holes
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h08, 32'h0, "R12 hole 08");
        rd(5'h00, 32'h0008_4000, "R12 ctrl untouched");

        // R11 unit reset over pending command
        wr(5'h0C, 32'h3C);
        ev_tx_empty = 1; tick(); ev_tx_empty = 0;
        wr(5'h00, 32'h0008_4009);
        wr(5'h00, 32'h0000_4400);
        ev_bus_err = 1; tick(); ev_bus_err = 0;
        rd(5'h00, 32'h0000_4401, "R11 command dropped");
        rd(5'h04, 32'h0, "R11 status held clear");
        rd(5'h0C, 32'h0, "R11 data held clear");
        sig("R11 unit_rst high", unit_rst, 1'b1);
        wr(5'h00, 32'h0);
        wr(5'h00, 32'h0000_4000);

        // R8 rx priority
        ev_rx_full = 1; rx_byte = 8'h5E; wr(5'h0C, 32'h11); ev_rx_full = 0;
        rd(5'h0C, 32'h5E, "R8 rx beats write");
        rd(5'h04, 32'h0010_0000, "R6 rx sticky");

        // mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int k;
            k = $urandom_range(0, 5);
            bus_addr = (k == 0) ? 5'h00 : (k == 1) ? 5'h04 : (k == 2) ? 5'h08 :
                       (k == 3) ? 5'h0C : (k == 4) ? 5'h10 : 5'h1C;
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_wdata = $urandom;
            if (bus_addr == 5'h00 && $urandom_range(0, 7) != 0) bus_wdata[10] = 1'b0;
            if (bus_addr == 5'h00 && $urandom_range(0, 3) != 0) bus_wdata[14] = 1'b1;
            cmd_ready = ($urandom_range(0, 2) == 0);
            ev_arb_lost = ($urandom_range(0, 7) == 0);
            ev_tx_empty = ($urandom_range(0, 5) == 0);
            ev_rx_full = ($urandom_range(0, 5) == 0);
            rx_byte = 8'($urandom);
            ev_bus_err = ($urandom_range(0, 7) == 0);
            ev_master_stop = ($urandom_range(0, 5) == 0);
            lvl_nak = 1'($urandom); lvl_bus_busy = 1'($urandom);
            sda_in = 1'($urandom); scl_in = 1'($urandom);
            tick();
        end
        bus_wr = 0; cmd_ready = 0;
        ev_arb_lost = 0; ev_tx_empty = 0; ev_rx_full = 0; ev_bus_err = 0; ev_master_stop = 0;
        tick();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule